// File: doc/BRIEF.md
# Four-Output Command Time-Multiplex Sequencer

This block sends four signed current commands to four external sample-and-hold stages. It has only two DAC channels to do it with. Each command becomes one DAC word. The top 12 bits of the word carry the command value. The low 4 bits carry a one-hot select code, and those bits also drive four strobe lines. Even-numbered outputs share the first DAC channel and odd-numbered outputs share the second. Every output has a pulse stretcher. It starts a sample-enable pulse of fixed length on the rising edge of that output's strobe, and a strobe that stays high longer does not lengthen the pulse.

A start handshake takes in a set of four commands. The sequencer then refreshes the outputs in the fixed order 0, 1, 2, 3. For each output it first places the value on its DAC channel, then raises the strobe. It moves to the next output only after the current output's enable pulse has ended. A stop request lets any pulse in progress finish, drops all strobes, and then runs the same sequence with a zero-current code. This keeps idle hold stages from drifting.

Top module: `cmd_tdm_seq`

## Requirements
- R1: After reset the following hold: both DAC words are zero, all sample enables are low, `startReady` is high, and `busy` and `done` are low.
- R2: The word for output k carries command k in bits [15:4]. Bits [3:0] hold the one-hot code with only bit k set: 0001 for output 0, 0010 for 1, 0100 for 2, 1000 for 3.
- R3: Outputs 0 and 2 are written to `dacWord0` and outputs 1 and 3 to `dacWord1`. While one word holds a strobe bit, the other word's low nibble is zero.
- R4: Sample enables rise in the order 0, 1, 2, 3 in every sequence, and never more than one is high at a time.
- R5: Each sample enable stays high for exactly PULSE_CYCLES = CLK_MHZ*PULSE_NS/1000 cycles after its strobe rises. The pulse is not lengthened by a strobe that stays high, and a strobe edge that arrives during the pulse does not restart it.
- R6: The value of an output is on its DAC word with a zero nibble one cycle before the strobe bit is set. That value field stays unchanged while the output's enable is high.
- R7: `startReady` is high only when the sequencer is idle or done. The commands on `cmdIn` are captured in the accepting cycle, and later changes to `cmdIn` have no effect. A start request while busy is ignored.
- R8: `done` rises one cycle after the enable of output 3 falls in a normal sequence. It stays high until the next accepted request. `busy` is high between acceptance and completion.
- R9: A stop request first lets any active pulse finish. It then writes the zero code (0x000) to all four outputs in order, each with its pulse, and returns to idle with `done` low. A stop wins over a start request in the same cycle, and a stop during a zeroing sequence is ignored.
- R10: The enable of output 0 rises on the third clock edge after the edge that accepts a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Request to load a new command set |
| startReady | output | 1 | High when a start request can be accepted |
| stopReq | input | 1 | Request to drive zero current to all outputs |
| cmdIn | input | 48 | Four 12-bit two's complement commands; output k in bits [12k+11:12k] |
| dacWord0 | output | 16 | Word for DAC channel 0 (outputs 0 and 2) |
| dacWord1 | output | 16 | Word for DAC channel 1 (outputs 1 and 3) |
| sampleEn | output | 4 | Sample-enable pulse for each hold stage |
| busy | output | 1 | A sequence or stop is in progress |
| done | output | 1 | The last normal sequence has completed |

## Verification
After the accepting edge, the value field of output 0 is due at the second falling edge and its strobe bit at the third. The enable is due at the fourth falling edge, which is three clock edges after acceptance. Every later output's value appears one edge after the previous enable is seen low. A monitor checks word contents and order at the falling edge on which each enable is first seen high. It counts the high falling edges of every pulse against PULSE_CYCLES, and it expects `done` exactly one falling edge after the output 3 enable is seen low. Stimulus changes only at falling edges, and expected commands are updated only after the clock edge that accepts a request.

// File: rtl/cmd_tdm_pkg.sv
package cmd_tdm_pkg;

  localparam int NUM_OUT = 4;
  localparam int DAC_CH  = 2;
  localparam int SLOT_W  = $clog2(NUM_OUT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_BLANK,
    ST_STROBE,
    ST_GAP,
    ST_HOLD,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic              loadCmd;
    logic              loadZero;
    logic              writeValue;
    logic              setStrobe;
    logic              clearStrobe;
    logic [SLOT_W-1:0] slot;
  } tdmCtrl_t;

endpackage

// File: rtl/cmd_tdm_pulse.sv
module cmd_tdm_pulse #(
  parameter int PULSE_CYCLES = 3750,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobe,
  output logic sampleEn
);

  logic             strobePrev;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      sampleEn   <= 1'b0;
      remain     <= '0;
    end else begin
      strobePrev <= strobe;
      if (strobe && !strobePrev && !sampleEn) begin
        // edge while idle: start a fresh window
        sampleEn <= 1'b1;
        remain   <= CNT_W'(PULSE_CYCLES - 1);
      end else if (sampleEn) begin
        // edges during the window are ignored
        if (remain == '0) sampleEn <= 1'b0;
        else              remain   <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmd_tdm_ctrl.sv
module cmd_tdm_ctrl
  import cmd_tdm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               stopReq,
  input  logic [NUM_OUT-1:0] sampleEn,
  output tdmCtrl_t           ctrl,
  output logic               startReady,
  output logic               busy,
  output logic               done
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_OUT - 1);

  seqState_t         state;
  logic [SLOT_W-1:0] slot;
  logic              clearRun;
  logic              drainSeen;
  logic              startAcc;
  logic              stopAcc;

  assign startReady = (state == ST_IDLE) || (state == ST_DONE);
  assign busy       = !startReady;
  assign done       = (state == ST_DONE);
  assign startAcc   = startReady && startValid && !stopReq;
  assign stopAcc    = stopReq && !clearRun;

  always_comb begin
    ctrl             = '0;
    ctrl.loadCmd     = startAcc;
    ctrl.loadZero    = stopAcc;
    ctrl.writeValue  = (state == ST_BLANK);
    ctrl.setStrobe   = (state == ST_STROBE);
    ctrl.clearStrobe = (state == ST_DRAIN);
    ctrl.slot        = slot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slot      <= '0;
      clearRun  <= 1'b0;
      drainSeen <= 1'b0;
    end else if (stopAcc) begin
      state     <= ST_DRAIN;
      slot      <= '0;
      clearRun  <= 1'b1;
      drainSeen <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (startAcc) begin
            state    <= ST_BLANK;
            slot     <= '0;
            clearRun <= 1'b0;
          end
        end
        ST_DRAIN: begin
          drainSeen <= 1'b1;
          if (drainSeen && (sampleEn == '0)) state <= ST_BLANK;
        end
        ST_BLANK:  state <= ST_STROBE;
        ST_STROBE: state <= ST_GAP;
        ST_GAP:    state <= ST_HOLD;
        ST_HOLD: begin
          if (!sampleEn[slot]) begin
            if (slot == LAST_SLOT) begin
              state    <= clearRun ? ST_IDLE : ST_DONE;
              clearRun <= 1'b0;
            end else begin
              slot  <= slot + 1'b1;
              state <= ST_BLANK;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_tdm_datapath.sv
module cmd_tdm_datapath
  import cmd_tdm_pkg::*;
#(
  parameter int CMD_W = 12,
  localparam int WORD_W = CMD_W + NUM_OUT
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tdmCtrl_t                      ctrl,
  input  logic [NUM_OUT*CMD_W-1:0]      cmdIn,
  output logic [DAC_CH-1:0][WORD_W-1:0] dacWord
);

  logic [CMD_W-1:0]   cmdReg [NUM_OUT];
  logic [NUM_OUT-1:0] selCode;
  logic [CMD_W-1:0]   selValue;

  assign selCode  = NUM_OUT'(1) << ctrl.slot;
  assign selValue = cmdReg[ctrl.slot];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_cmd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cmdReg[k] <= '0;
      else if (ctrl.loadZero) cmdReg[k] <= '0;
      else if (ctrl.loadCmd)  cmdReg[k] <= cmdIn[k*CMD_W +: CMD_W];
    end
  end

  for (genvar ch = 0; ch < DAC_CH; ch++) begin : g_chan
    logic mine;
    assign mine = (32'(ctrl.slot) % DAC_CH) == ch;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dacWord[ch] <= '0;
      end else if (ctrl.clearStrobe) begin
        dacWord[ch][NUM_OUT-1:0] <= '0;
      end else if (ctrl.writeValue) begin
        if (mine) dacWord[ch] <= {selValue, {NUM_OUT{1'b0}}};
        else      dacWord[ch][NUM_OUT-1:0] <= '0;
      end else if (ctrl.setStrobe && mine) begin
        dacWord[ch][NUM_OUT-1:0] <= selCode;
      end
    end
  end

endmodule

// File: rtl/cmd_tdm_seq.sv
module cmd_tdm_seq
  import cmd_tdm_pkg::*;
#(
  parameter int CMD_W    = 12,
  parameter int CLK_MHZ  = 250,
  parameter int PULSE_NS = 15000,
  localparam int WORD_W       = CMD_W + NUM_OUT,
  localparam int PULSE_CYCLES = CLK_MHZ * PULSE_NS / 1000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startValid,
  output logic                     startReady,
  input  logic                     stopReq,
  input  logic [NUM_OUT*CMD_W-1:0] cmdIn,
  output logic [WORD_W-1:0]        dacWord0,
  output logic [WORD_W-1:0]        dacWord1,
  output logic [NUM_OUT-1:0]       sampleEn,
  output logic                     busy,
  output logic                     done
);

  tdmCtrl_t                      ctrl;
  logic [DAC_CH-1:0][WORD_W-1:0] dacWord;

  cmd_tdm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .stopReq    (stopReq),
    .sampleEn   (sampleEn),
    .ctrl       (ctrl),
    .startReady (startReady),
    .busy       (busy),
    .done       (done)
  );

  cmd_tdm_datapath #(.CMD_W(CMD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .cmdIn   (cmdIn),
    .dacWord (dacWord)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_hold
    cmd_tdm_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (dacWord[k % DAC_CH][k]),
      .sampleEn (sampleEn[k])
    );
  end

  assign dacWord0 = dacWord[0];
  assign dacWord1 = dacWord[1];

endmodule

// File: rtl/cmd_tdm_checker.sv
module cmd_tdm_checker #(
  parameter int CMD_W        = 12,
  parameter int PULSE_CYCLES = 3750,
  localparam int WORD_W = CMD_W + 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] dacWord0,
  input logic [WORD_W-1:0] dacWord1,
  input logic [3:0]        sampleEn,
  input logic              startReady,
  input logic              busy,
  input logic              done
);

  logic [31:0] hiCnt;
  logic [3:0]  strobes;

  assign strobes = {dacWord1[3], dacWord0[2], dacWord1[1], dacWord0[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hiCnt <= '0;
    else if (|sampleEn) hiCnt <= hiCnt + 1;
    else                hiCnt <= '0;
  end

  AST_CHANNEL_MAP: assert property (@(posedge clk) disable iff (!rstN)
    !dacWord0[1] && !dacWord0[3] && !dacWord1[0] && !dacWord1[2] && $onehot0(strobes)); // R3

  AST_ENABLE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sampleEn)); // R4

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (!(|sampleEn) && hiCnt != 0) |-> hiCnt == PULSE_CYCLES); // R5

  for (genvar k = 0; k < 4; k++) begin : g_rise
    AST_RISE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(sampleEn[k]) |-> $past(strobes[k])); // R5
  end

  AST_VALUE_STABLE_CH0: assert property (@(posedge clk) disable iff (!rstN)
    ((sampleEn[0] || sampleEn[2]) && $past(sampleEn[0] || sampleEn[2]))
      |-> $stable(dacWord0[WORD_W-1:4])); // R6

  AST_VALUE_STABLE_CH1: assert property (@(posedge clk) disable iff (!rstN)
    ((sampleEn[1] || sampleEn[3]) && $past(sampleEn[1] || sampleEn[3]))
      |-> $stable(dacWord1[WORD_W-1:4])); // R6

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    startReady |-> !busy); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sampleEn == 4'b0000); // R8

endmodule

bind cmd_tdm_seq cmd_tdm_checker #(
  .CMD_W        (CMD_W),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dacWord0   (dacWord0),
  .dacWord1   (dacWord1),
  .sampleEn   (sampleEn),
  .startReady (startReady),
  .busy       (busy),
  .done       (done)
);

// File: tb/tb_cmd_tdm_seq.sv
`timescale 1ns/1ps
module tb_cmd_tdm_seq;

  localparam int P = 25; // 250 MHz * 100 ns

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        stopReq = 1'b0;
  logic [47:0] cmdIn = '0;
  logic        startReady, busy, done;
  logic [15:0] dacWord0, dacWord1;
  logic [3:0]  sampleEn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [11:0] expCmd [4];
  int          expNext = 0;
  bit          clearRunTb = 1'b0;
  bit          doneDue = 1'b0;
  logic [3:0]  prevEn = '0;
  int          hiCnt [4];

  always #2 clk = ~clk;

  cmd_tdm_seq #(.CMD_W(12), .CLK_MHZ(250), .PULSE_NS(100)) dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .stopReq(stopReq), .cmdIn(cmdIn), .dacWord0(dacWord0), .dacWord1(dacWord1),
    .sampleEn(sampleEn), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expWord(input int k, input logic [11:0] v);
    return {v, 4'(1 << k)};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Monitor: order, word contents, widths, done timing (R2 R3 R4 R5 R8)
  always @(negedge clk) begin
    if (rstN) begin
      if (doneDue) begin
        chk(done == !clearRunTb, "R8 done after last pulse", done, !clearRunTb);
        doneDue = 1'b0;
      end
      for (int k = 0; k < 4; k++) begin
        if (sampleEn[k]) hiCnt[k]++;
        if (sampleEn[k] && !prevEn[k]) begin
          logic [15:0] w, o;
          w = (k % 2) ? dacWord1 : dacWord0;
          o = (k % 2) ? dacWord0 : dacWord1;
          chk(k == expNext, "R4 order", k, expNext);
          expNext = (k + 1) % 4;
          chk(w == expWord(k, expCmd[k]), "R2 word", w, expWord(k, expCmd[k]));
          chk(o[3:0] == 4'b0, "R3 other nibble", o[3:0], 0);
          chk(busy == 1'b1, "R8 busy", busy, 1);
        end
        if (!sampleEn[k] && prevEn[k]) begin
          chk(hiCnt[k] == P, "R5 width", hiCnt[k], P);
          hiCnt[k] = 0;
          if (k == 3) doneDue = 1'b1;
        end
      end
      prevEn = sampleEn;
    end
  end

  task automatic waitReady();
    @(negedge clk);
    while (!startReady) @(negedge clk);
  endtask

  task automatic startRun(input logic [11:0] c0, c1, c2, c3);
    waitReady();
    startValid = 1'b1;
    cmdIn = {c3, c2, c1, c0};
    @(posedge clk);
    expCmd[0] = c0; expCmd[1] = c1; expCmd[2] = c2; expCmd[3] = c3;
    expNext = 0;
    clearRunTb = 1'b0;
    @(negedge clk);
    startValid = 1'b0;
    cmdIn = {$urandom, $urandom}; // R7: later input changes must not matter
    chk(startReady == 1'b0, "R7 ready low when busy", startReady, 0);
    @(negedge clk);
    chk(dacWord0 == {c0, 4'b0}, "R6 value before strobe", dacWord0, {c0, 4'b0});
    @(negedge clk);
    chk(sampleEn == 4'b0 && dacWord0[3:0] == 4'b0001, "R10 strobe no enable yet",
        {sampleEn, dacWord0[3:0]}, 1);
    @(negedge clk);
    chk(sampleEn == 4'b0001, "R10 enable on third edge", sampleEn, 1);
  endtask

  task automatic stopNow(input bit withStart);
    stopReq = 1'b1;
    startValid = withStart;
    @(posedge clk);
    for (int k = 0; k < 4; k++) expCmd[k] = '0;
    expNext = 0;
    clearRunTb = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    startValid = 1'b0;
  endtask

  task automatic checkCleared();
    waitReady();
    chk(done == 1'b0, "R9 done low after zeroing", done, 0);
    chk(dacWord0[15:4] == 0 && dacWord1[15:4] == 0, "R9 zero values",
        {dacWord0[15:4], dacWord1[15:4]}, 0);
    chk(sampleEn == 4'b0, "R9 enables idle", sampleEn, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) begin expCmd[k] = '0; hiCnt[k] = 0; end
    repeat (4) @(negedge clk);
    chk(dacWord0 == 0 && dacWord1 == 0, "R1 words", {dacWord0, dacWord1}, 0);
    chk(sampleEn == 0 && startReady && !busy && !done, "R1 flags",
        {sampleEn, startReady, busy, done}, 8'h04);
    rstN = 1'b1;

    // Directed extremes
    startRun(12'h7FF, 12'h800, 12'h001, 12'hFFF);
    waitReady();
    chk(done == 1'b1, "R8 done held", done, 1);
    repeat (37) @(negedge clk);
    chk(sampleEn == 4'b0 && dacWord1[3] == 1'b1, "R5 long strobe no pulse",
        {sampleEn, dacWord1[3]}, 1);
    chk(done == 1'b1, "R8 done stays", done, 1);

    // Stop from done, then stop and start together
    stopNow(1'b0);
    checkCleared();
    stopNow(1'b1);
    checkCleared();

    // Random runs with spurious starts and mid-pulse stops
    for (int r = 0; r < 30; r++) begin
      startRun(12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom));
      repeat ($urandom_range(0, 60)) @(negedge clk);
      if (!startReady) begin
        startValid = 1'b1; // R7: ignored while busy
        cmdIn = {$urandom, $urandom};
        chk(startReady == 1'b0, "R7 busy refuses start", startReady, 0);
        @(negedge clk);
        startValid = 1'b0;
      end
      if ($urandom_range(0, 2) == 0) begin
        while (sampleEn == 0 && !startReady) @(negedge clk);
        stopNow(1'b0);
        repeat (3) @(negedge clk);
        stopReq = 1'b1; // R9: ignored during zeroing
        @(negedge clk);
        stopReq = 1'b0;
        checkCleared();
      end else begin
        waitReady();
        chk(done == 1'b1, "R8 done at end", done, 1);
      end
    end

    repeat (5) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule